// File: doc/BRIEF.md
# Partitioned Packed-Integer ALU

This block is a single-cycle integer datapath for packed operands. A 64-bit operand pair is treated either as a full 64-bit word or, in narrow mode, as a 32-bit word held in the low half. Within that word the operands are split into 16-bit or 32-bit lanes. Each lane is added or subtracted on its own, with carries stopped at lane edges.

The same unit also provides the two-operand bitwise functions and the two constant fills. It also compares the lanes as signed numbers. A compare folds the per-lane outcomes into a short bit mask at the bottom of the result.

A caller presents the operands, an opcode, a lane-size select and a width select together with `in_valid`. The result is registered and appears one clock later, flagged by `out_valid`.

Top module: `psimd_alu`

## Requirements
- R1: Opcode encoding: 0 add, 1 subtract, 2 not, 3 nor, 4 or, 5 xor, 6 and, 7 or-not, 8 and-not, 9 nand, 10 xnor, 11 fill-zero, 12 fill-ones, 13 greater-than, 14 equal, 15 less-or-equal, 16 not-equal. Any opcode from 17 to 31 yields an all-zero result. `src_a` is the first operand and `src_b` the second.
- R2: With `lane32`=0 each 16-bit lane computes a+b or a-b modulo 2^16. No carry or borrow passes into the next lane.
- R3: With `lane32`=1 each 32-bit lane computes a+b or a-b modulo 2^32. The carry does pass between the two 16-bit halves inside a lane.
- R4: Not gives ~b, nor ~(a|b), or a|b, xor a^b, and a&b, or-not a|~b, and-not a&~b, nand ~(a&b), xnor ~(a^b).
- R5: Fill-zero gives all zeros and fill-ones gives all ones across the selected width.
- R6: A compare treats each lane of a and b as signed two's complement and tests a>b, a==b, a<=b or a!=b. The outcome for lane i goes to result bit i. All result bits above the lane count are zero.
- R7: With `wide`=1 the word is 64 bits, giving four 16-bit lanes or two 32-bit lanes. With `wide`=0 only bits 31:0 take part, giving two 16-bit lanes or one 32-bit lane, and result bits 63:32 are zero.
- R8: `out_valid` is `in_valid` delayed by one clock. `result` loads only when `in_valid` is high and otherwise holds its value.
- R9: While `rst_n` is low, `result` and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| opcode | input | 5 | Operation code (R1) |
| lane32 | input | 1 | 1: 32-bit lanes, 0: 16-bit lanes |
| wide | input | 1 | 1: 64-bit word, 0: 32-bit word |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Every operation passes through exactly one register, so each result and its `out_valid` are due at the first rising edge after the request. The bench drives a request on a falling edge and samples on the next falling edge, half a cycle after that rising edge. It then idles one further cycle with different operands and checks that `out_valid` has dropped and that `result` has held. The sweep covers every opcode, both lane sizes, both widths and a set of boundary and pseudo-random operand pairs. It also drives several unused opcodes.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_SUB  = 5'd1,
      OP_NOT  = 5'd2,
      OP_NOR  = 5'd3,
      OP_OR   = 5'd4,
      OP_XOR  = 5'd5,
      OP_AND  = 5'd6,
      OP_ORN  = 5'd7,
      OP_ANDN = 5'd8,
      OP_NAND = 5'd9,
      OP_XNOR = 5'd10,
      OP_ZERO = 5'd11,
      OP_ONES = 5'd12,
      OP_CGT  = 5'd13,
      OP_CEQ  = 5'd14,
      OP_CLE  = 5'd15,
      OP_CNE  = 5'd16
   } psimd_op_e;

   typedef enum logic [1:0] {
      PRED_GT = 2'd0,
      PRED_EQ = 2'd1,
      PRED_LE = 2'd2,
      PRED_NE = 2'd3
   } psimd_pred_e;

endpackage

// File: rtl/psimd_addsub.sv
module psimd_addsub #(
   parameter int DW  = 64,
   parameter int SEG = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   input  logic          lane32,
   output logic [DW-1:0] sum
);
   localparam int NSEG = DW / SEG;

   logic [NSEG-1:0] cy;   // carry out of each segment except the last

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG-1:0] a_s, bx_s;
      logic           cin;
      assign a_s  = a[g*SEG +: SEG];
      assign bx_s = sub ? ~b[g*SEG +: SEG] : b[g*SEG +: SEG];
      if (g % 2 == 1) begin : g_hi
         assign cin = lane32 ? cy[g-1] : sub;
      end else begin : g_lo
         assign cin = sub;
      end
      if (g < NSEG - 1) begin : g_chain
         logic [SEG:0] ext;
         assign ext = {1'b0, a_s} + {1'b0, bx_s} + {{SEG{1'b0}}, cin};
         assign sum[g*SEG +: SEG] = ext[SEG-1:0];
         assign cy[g] = ext[SEG];
      end else begin : g_last
         assign sum[g*SEG +: SEG] = a_s + bx_s + {{(SEG-1){1'b0}}, cin};
         assign cy[g] = 1'b0;
      end
   end

   // Lowest lane never sees a carry-in on add (R2)
   always_comb begin
      if (!sub)
         p_seg0_add_r2: assert (sum[SEG-1:0] == SEG'(a[SEG-1:0] + b[SEG-1:0]));
   end

endmodule

// File: rtl/psimd_logic.sv
module psimd_logic #(
   parameter int DW = 64
) (
   input  psimd_pkg::psimd_op_e op,
   input  logic [DW-1:0]        a,
   input  logic [DW-1:0]        b,
   output logic [DW-1:0]        y
);
   import psimd_pkg::*;

   always_comb begin
      case (op)
         OP_NOT:  y = ~b;
         OP_NOR:  y = ~(a | b);
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_AND:  y = a & b;
         OP_ORN:  y = a | ~b;
         OP_ANDN: y = a & ~b;
         OP_NAND: y = ~(a & b);
         OP_XNOR: y = ~(a ^ b);
         OP_ONES: y = '1;
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/psimd_cmp.sv
module psimd_cmp #(
   parameter int DW  = 64,
   parameter int SEG = 16
) (
   input  logic [DW-1:0]          a,
   input  logic [DW-1:0]          b,
   input  psimd_pkg::psimd_pred_e pred,
   input  logic                   lane32,
   input  logic                   wide,
   output logic [DW/SEG-1:0]      mask
);
   import psimd_pkg::*;

   localparam int NSEG  = DW / SEG;
   localparam int NPAIR = NSEG / 2;

   logic [NSEG-1:0]  eq_s, ugt_s, sgt_s, hit_s;
   logic [NPAIR-1:0] eq_p, sgt_p, hit_p;

   function automatic logic apply(input psimd_pred_e p, input logic gt, input logic eq);
      case (p)
         PRED_GT: apply = gt;
         PRED_EQ: apply = eq;
         PRED_LE: apply = !gt;
         default: apply = !eq;
      endcase
   endfunction

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEG-1:0] as, bs;
      assign as       = a[g*SEG +: SEG];
      assign bs       = b[g*SEG +: SEG];
      assign eq_s[g]  = (as == bs);
      assign ugt_s[g] = (as > bs);
      assign sgt_s[g] = ($signed(as) > $signed(bs));
      assign hit_s[g] = apply(pred, sgt_s[g], eq_s[g]) && (wide || g < NSEG/2);
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign eq_p[p]  = eq_s[2*p+1] & eq_s[2*p];
      assign sgt_p[p] = sgt_s[2*p+1] | (eq_s[2*p+1] & ugt_s[2*p]);
      assign hit_p[p] = apply(pred, sgt_p[p], eq_p[p]) && (wide || p < NPAIR/2);
   end

   always_comb begin
      mask = '0;
      if (lane32) mask[NPAIR-1:0] = hit_p;
      else        mask = hit_s;
   end

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu #(
   parameter int DW  = 64,
   parameter int SEG = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [4:0]    opcode,
   input  logic          lane32,
   input  logic          wide,
   input  logic [DW-1:0] src_a,
   input  logic [DW-1:0] src_b,
   output logic          out_valid,
   output logic [DW-1:0] result
);
   import psimd_pkg::*;

   localparam int HW   = DW / 2;
   localparam int NSEG = DW / SEG;

   if (DW % (4 * SEG) != 0) begin : g_bad_width
      $error("psimd_alu: DW must be a multiple of 4*SEG");
   end
   if (SEG < 2) begin : g_bad_seg
      $error("psimd_alu: SEG must be at least 2");
   end

   psimd_op_e   op;
   psimd_pred_e pred;
   logic        is_arith, is_cmp, is_logic;
   logic [DW-1:0]   sum, lres, nxt, wmask;
   logic [NSEG-1:0] cmask;

   assign op       = psimd_op_e'(opcode);
   assign is_arith = (opcode == OP_ADD) || (opcode == OP_SUB);
   assign is_cmp   = (opcode >= OP_CGT) && (opcode <= OP_CNE);
   assign is_logic = (opcode >= OP_NOT) && (opcode <= OP_ONES);
   assign pred     = psimd_pred_e'(opcode - OP_CGT);
   assign wmask    = wide ? {DW{1'b1}} : {{HW{1'b0}}, {HW{1'b1}}};

   psimd_addsub #(.DW(DW), .SEG(SEG)) u_addsub (
      .a(src_a), .b(src_b), .sub(opcode == OP_SUB), .lane32(lane32), .sum(sum)
   );

   psimd_logic #(.DW(DW)) u_logic (
      .op(op), .a(src_a), .b(src_b), .y(lres)
   );

   psimd_cmp #(.DW(DW), .SEG(SEG)) u_cmp (
      .a(src_a), .b(src_b), .pred(pred), .lane32(lane32), .wide(wide), .mask(cmask)
   );

   always_comb begin
      if (is_arith)      nxt = sum & wmask;
      else if (is_logic) nxt = lres & wmask;
      else if (is_cmp)   nxt = {{(DW-NSEG){1'b0}}, cmask};
      else               nxt = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end

   p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide) |=> (result[DW-1:HW] == '0));
   p_cmp_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_cmp) |=> (result[DW-1:NSEG] == '0));
   p_fill_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide && opcode == OP_ONES) |=> (&result));

endmodule

// File: tb/psimd_alu_tb.sv
module psimd_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  opcode = '0;
   logic        lane32 = 1'b0;
   logic        wide = 1'b0;
   logic [63:0] src_a = '0;
   logic [63:0] src_b = '0;
   logic        out_valid;
   logic [63:0] result;

   int tests = 0;
   int fails = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #10 clk = ~clk;

   psimd_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .lane32(lane32), .wide(wide), .src_a(src_a), .src_b(src_b),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] model(input int op, input logic l32, input logic w,
                                         input logic [63:0] a, input logic [63:0] b);
      int L, n;
      logic [63:0] wm, lm, r, la, lb, v;
      longint sa, sb;
      logic bit_v;
      L  = l32 ? 32 : 16;
      n  = (w ? 64 : 32) / L;
      wm = w ? '1 : 64'h0000_0000_FFFF_FFFF;
      lm = (64'd1 << L) - 64'd1;
      r  = '0;
      case (op)
         0, 1: begin
            for (int k = 0; k < n; k++) begin
               la = (a >> (k*L)) & lm;
               lb = (b >> (k*L)) & lm;
               v  = (op == 0) ? (la + lb) : (la - lb);
               r  = r | ((v & lm) << (k*L));
            end
         end
         2:  r = ~b & wm;
         3:  r = ~(a | b) & wm;
         4:  r = (a | b) & wm;
         5:  r = (a ^ b) & wm;
         6:  r = (a & b) & wm;
         7:  r = (a | ~b) & wm;
         8:  r = (a & ~b) & wm;
         9:  r = ~(a & b) & wm;
         10: r = ~(a ^ b) & wm;
         11: r = '0;
         12: r = wm;
         13, 14, 15, 16: begin
            for (int k = 0; k < n; k++) begin
               sa = longint'(((a >> (k*L)) & lm) << (64-L)) >>> (64-L);
               sb = longint'(((b >> (k*L)) & lm) << (64-L)) >>> (64-L);
               case (op)
                  13: bit_v = sa > sb;
                  14: bit_v = sa == sb;
                  15: bit_v = sa <= sb;
                  default: bit_v = sa != sb;
               endcase
               r[k] = bit_v;
            end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag(input int op);
      if (op <= 1) return "R2/R3/R7";
      if (op <= 10) return "R4/R7";
      if (op <= 12) return "R5/R7";
      if (op <= 16) return "R6/R7";
      return "R1";
   endfunction

   task automatic run(input int op, input logic l32, input logic w,
                      input logic [63:0] a, input logic [63:0] b);
      logic [63:0] exp;
      exp = model(op, l32, w, a, b);
      @(negedge clk);
      opcode = op[4:0]; lane32 = l32; wide = w; src_a = a; src_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 out_valid high", {63'd0, out_valid}, 64'd1);
      check(tag(op), result, exp);
      src_a = ~a; src_b = b ^ 64'h5A5A_5A5A_5A5A_5A5A; opcode = 5'd12;
      @(negedge clk);
      check("R8 out_valid low", {63'd0, out_valid}, 64'd0);
      check("R8 hold", result, exp);
   endtask

   function automatic logic [63:0] next_rng(input logic [63:0] s);
      logic [63:0] x;
      x = s ^ (s << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   logic [63:0] pa [12];
   logic [63:0] pb [12];

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      // boundary patterns: lane carries, signed extremes, equal lanes
      pa[0] = 64'h0000_0000_0000_0000; pb[0] = 64'h0000_0000_0000_0000;
      pa[1] = 64'hFFFF_FFFF_FFFF_FFFF; pb[1] = 64'h0001_0001_0001_0001;
      pa[2] = 64'h7FFF_8000_7FFF_FFFF; pb[2] = 64'h8000_7FFF_0001_0001;
      pa[3] = 64'h0000_FFFF_8000_0000; pb[3] = 64'h0000_0001_7FFF_FFFF;
      pa[4] = 64'h1234_5678_9ABC_DEF0; pb[4] = 64'h1234_5678_9ABC_DEF0;
      pa[5] = 64'h0000_0000_0000_0000; pb[5] = 64'hFFFF_0001_FFFF_0001;
      pa[6] = 64'h8000_0000_8000_0000; pb[6] = 64'h7FFF_FFFF_0000_0000;
      pa[7] = 64'hFFFF_0000_1234_FFFF; pb[7] = 64'hFFFF_0001_1234_FFFE;
      for (int i = 8; i < 12; i++) begin
         rng = next_rng(rng); pa[i] = rng;
         rng = next_rng(rng); pb[i] = rng;
      end

      // R9: reset state
      src_a = '1; src_b = '1; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset result", result, 64'd0);
      check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle after reset", result, 64'd0);

      for (int op = 0; op <= 16; op++)
         for (int m = 0; m < 4; m++)
            for (int i = 0; i < 12; i++)
               run(op, m[0], m[1], pa[i], pb[i]);

      // R1: unused opcodes give zero
      for (int op = 17; op < 32; op++)
         run(op, op[0], op[1], 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule